// File: doc/BRIEF.md
# Configurable Interrupt Routing Matrix

The block takes 128 interrupt request lines and concentrates them onto 24 output lines. Software sets up the mapping at run time. Each input has one 32-bit configuration word. The word carries an enable flag and the index of the output line that the input should drive. Each output is the OR of every enabled input whose selected index names it. Several sources can therefore share one output, and a source given an output of its own reaches it alone.

A second, read-only area holds the raw level of all 128 inputs, packed 32 per word. A handler that serves a shared output reads these words to find which sources are requesting. Access is through a plain memory-mapped port with a byte address, a write strobe with write data, and a read strobe whose data appears on the following cycle. Edge detection, priority and acknowledge belong to the interrupt controller downstream.

Top module: `irq_route_matrix`

## Requirements
- R1: After reset every configuration word reads as zero and every bit of `irq_out` is low, even while all inputs are high.
- R2: A write to byte address 4·n (n from 0 to 127) stores bit 31 as the enable of input n and bits [4:0] as its output select. A read of that address returns the enable in bit 31, the select in bits [4:0], and zero in bits [30:5].
- R3: One clock after the inputs and configuration are present, `irq_out[k]` is the OR of `irq_in[n]` over all n whose enable is 1 and whose select equals k.
- R4: An input whose enable is 0 drives no output. Writing the value zero to its configuration word disables it.
- R5: An enabled input whose select is 24 or larger drives no output.
- R6: When several enabled inputs select the same output, that output is high whenever any one of them is high.
- R7: A read of byte address 0x420 + 4·w (w from 0 to 3) returns `irq_in[32w+b]` in bit b. The value is sampled in the cycle of the read strobe and does not depend on any enable.
- R8: Writes to the status words and to unmapped addresses change no configuration word and no output. A read of an unmapped address (0x200 to 0x41C, and 0x430 upward) returns zero.
- R9: `rd_data` is valid in the cycle after `rd_en` is high. In a cycle after one without `rd_en`, `rd_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 12 | Byte address for reads and writes |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Read data, registered one cycle after `rd_en` |
| irq_in | input | 128 | Interrupt request inputs, level sensitive |
| irq_out | output | 24 | Routed request outputs, registered |

## Verification
The assertions run on every cycle. They check that the outputs fall quiet under reset and that an output goes high only when some input was high a cycle earlier. They also check that a write of a cleared enable bit disables the input it addresses, and that the configuration holds still whenever no configuration write occurs. Finally, they cover the read data for status word 0, for unmapped addresses and for idle cycles. The exact routing function can only be shown by the bench. It covers full-width readback of all 128 words and walks a single active input across every position under a select pattern that includes the out-of-range values. It also drives shared-output patterns and rechecks the routing after selective disables and after writes that must be ignored.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  localparam int unsigned WORD_W = 32;

  typedef enum logic [1:0] {
    AREA_CFG  = 2'd0,
    AREA_STAT = 2'd1,
    AREA_NONE = 2'd2
  } area_e;

  // Classify a word index into configuration, status or unmapped space.
  function automatic area_e decode_area(int unsigned word, int unsigned n_cfg,
                                        int unsigned stat_base, int unsigned n_stat);
    if (word < n_cfg) return AREA_CFG;
    if (word >= stat_base && word < stat_base + n_stat) return AREA_STAT;
    return AREA_NONE;
  endfunction

  // Readback image of one configuration entry.
  function automatic logic [WORD_W-1:0] cfg_image(logic en, logic [7:0] sel, int unsigned sel_w);
    logic [WORD_W-1:0] img;
    img = '0;
    img[WORD_W-1] = en;
    for (int b = 0; b < 8; b++) begin
      if (b < int'(sel_w)) img[b] = sel[b];
    end
    return img;
  endfunction

endpackage

// File: rtl/irq_route_regs.sv
module irq_route_regs #(
  parameter int unsigned N_IN  = 128,
  parameter int unsigned SEL_W = 5,
  localparam int unsigned IDX_W = (N_IN > 1) ? $clog2(N_IN) : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_cfg,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic                        wr_en_bit,
  input  logic [SEL_W-1:0]            wr_sel,
  output logic [N_IN-1:0]             cfg_en,
  output logic [N_IN-1:0][SEL_W-1:0]  cfg_sel
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_en  <= '0;
      cfg_sel <= '0;
    end else if (wr_cfg) begin
      cfg_en[wr_idx]  <= wr_en_bit;
      cfg_sel[wr_idx] <= wr_sel;
    end
  end

endmodule

// File: rtl/irq_route_xbar.sv
module irq_route_xbar #(
  parameter int unsigned N_IN  = 128,
  parameter int unsigned N_OUT = 24,
  parameter int unsigned SEL_W = 5
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [N_IN-1:0]             irq_in,
  input  logic [N_IN-1:0]             cfg_en,
  input  logic [N_IN-1:0][SEL_W-1:0]  cfg_sel,
  output logic [N_OUT-1:0]            route_hit,
  output logic [N_OUT-1:0]            irq_out
);

  // One OR column per output line; a select beyond N_OUT matches no column.
  for (genvar o = 0; o < N_OUT; o++) begin : g_col
    always_comb begin
      route_hit[o] = 1'b0;
      for (int i = 0; i < int'(N_IN); i++) begin
        if (cfg_en[i] && (cfg_sel[i] == SEL_W'(o)))
          route_hit[o] = route_hit[o] | irq_in[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_out <= '0;
    else     irq_out <= route_hit;
  end

endmodule

// File: rtl/irq_route_rdmux.sv
module irq_route_rdmux
  import irq_route_pkg::*;
#(
  parameter int unsigned N_IN  = 128,
  parameter int unsigned SEL_W = 5,
  localparam int unsigned IDX_W  = (N_IN > 1) ? $clog2(N_IN) : 1,
  localparam int unsigned N_STAT = (N_IN + WORD_W - 1) / WORD_W,
  localparam int unsigned SW_W   = (N_STAT > 1) ? $clog2(N_STAT) : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        rd_en,
  input  area_e                       area,
  input  logic [IDX_W-1:0]            cfg_idx,
  input  logic [SW_W-1:0]             stat_idx,
  input  logic [N_IN-1:0]             cfg_en,
  input  logic [N_IN-1:0][SEL_W-1:0]  cfg_sel,
  input  logic [N_IN-1:0]             irq_in,
  output logic [WORD_W-1:0]           rd_data
);

  logic [N_STAT*WORD_W-1:0] irq_pad;
  logic [WORD_W-1:0]        cfg_word;
  logic [WORD_W-1:0]        stat_word;
  logic [7:0]               sel_ext;

  assign irq_pad   = {{(N_STAT*WORD_W-N_IN){1'b0}}, irq_in};
  assign sel_ext   = 8'(cfg_sel[cfg_idx]);
  assign cfg_word  = cfg_image(cfg_en[cfg_idx], sel_ext, SEL_W);
  assign stat_word = irq_pad[stat_idx*WORD_W +: WORD_W];

  always_ff @(posedge clk) begin
    if (rst || !rd_en) begin
      rd_data <= '0;
    end else begin
      unique case (area)
        AREA_CFG:  rd_data <= cfg_word;
        AREA_STAT: rd_data <= stat_word;
        default:   rd_data <= '0;
      endcase
    end
  end

endmodule

// File: rtl/irq_route_matrix.sv
module irq_route_matrix
  import irq_route_pkg::*;
#(
  parameter int unsigned N_IN      = 128,
  parameter int unsigned N_OUT     = 24,
  parameter int unsigned SEL_W     = 5,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned STAT_BASE = 32'h420
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  input  logic              rd_en,
  output logic [31:0]       rd_data,
  input  logic [N_IN-1:0]   irq_in,
  output logic [N_OUT-1:0]  irq_out
);

  localparam int unsigned IDX_W     = (N_IN > 1) ? $clog2(N_IN) : 1;
  localparam int unsigned N_STAT    = (N_IN + WORD_W - 1) / WORD_W;
  localparam int unsigned SW_W      = (N_STAT > 1) ? $clog2(N_STAT) : 1;
  localparam int unsigned STAT_WORD = STAT_BASE / 4;

  // Named decode events, visible to the checker.
  logic [ADDR_W-3:0]            word_idx;
  area_e                        area;
  logic                         wr_cfg;
  logic [IDX_W-1:0]             wr_idx;
  logic [SW_W-1:0]              stat_idx;
  logic [N_IN-1:0]              cfg_en;
  logic [N_IN-1:0][SEL_W-1:0]   cfg_sel;
  logic [N_OUT-1:0]             route_hit;

  assign word_idx = addr[ADDR_W-1:2];
  assign area     = decode_area(int'(word_idx), N_IN, STAT_WORD, N_STAT);
  assign wr_cfg   = wr_en && (area == AREA_CFG);
  assign wr_idx   = word_idx[IDX_W-1:0];
  assign stat_idx = SW_W'(word_idx - (ADDR_W-2)'(STAT_WORD));

  irq_route_regs #(.N_IN(N_IN), .SEL_W(SEL_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_cfg    (wr_cfg),
    .wr_idx    (wr_idx),
    .wr_en_bit (wr_data[31]),
    .wr_sel    (wr_data[SEL_W-1:0]),
    .cfg_en    (cfg_en),
    .cfg_sel   (cfg_sel)
  );

  irq_route_xbar #(.N_IN(N_IN), .N_OUT(N_OUT), .SEL_W(SEL_W)) u_xbar (
    .clk       (clk),
    .rst       (rst),
    .irq_in    (irq_in),
    .cfg_en    (cfg_en),
    .cfg_sel   (cfg_sel),
    .route_hit (route_hit),
    .irq_out   (irq_out)
  );

  irq_route_rdmux #(.N_IN(N_IN), .SEL_W(SEL_W)) u_rdmux (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .area     (area),
    .cfg_idx  (wr_idx),
    .stat_idx (stat_idx),
    .cfg_en   (cfg_en),
    .cfg_sel  (cfg_sel),
    .irq_in   (irq_in),
    .rd_data  (rd_data)
  );

endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk
  import irq_route_pkg::*;
#(
  parameter int unsigned N_IN      = 128,
  parameter int unsigned N_OUT     = 24,
  parameter int unsigned SEL_W     = 5,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned STAT_BASE = 32'h420,
  localparam int unsigned IDX_W = (N_IN > 1) ? $clog2(N_IN) : 1
) (
  input logic                        clk,
  input logic                        rst,
  input logic [ADDR_W-1:0]           addr,
  input logic                        wr_cfg,
  input logic [IDX_W-1:0]            wr_idx,
  input logic [31:0]                 wr_data,
  input logic                        rd_en,
  input logic [31:0]                 rd_data,
  input logic [N_IN-1:0]             irq_in,
  input logic [N_OUT-1:0]            irq_out,
  input area_e                       area,
  input logic [N_IN-1:0]             cfg_en,
  input logic [N_IN-1:0][SEL_W-1:0]  cfg_sel
);

  p_reset_quiet_r1: assert property (@(posedge clk) rst |=> (irq_out == '0));

  p_needs_input_r3: assert property (@(posedge clk) disable iff (rst)
    (irq_out != '0) |-> $past(irq_in != '0));

  p_write_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_cfg && !wr_data[31]) |=> !cfg_en[$past(wr_idx)]);

  p_stat_word0_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == ADDR_W'(STAT_BASE)) |=> (rd_data == $past(irq_in[31:0])));

  p_cfg_stable_r8: assert property (@(posedge clk) disable iff (rst)
    !wr_cfg |=> ($stable(cfg_en) && $stable(cfg_sel)));

  p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_en && area == AREA_NONE) |=> (rd_data == '0));

  p_idle_zero_r9: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (rd_data == '0));

endmodule

bind irq_route_matrix irq_route_chk #(
  .N_IN(N_IN), .N_OUT(N_OUT), .SEL_W(SEL_W), .ADDR_W(ADDR_W), .STAT_BASE(STAT_BASE)
) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .wr_cfg(wr_cfg), .wr_idx(wr_idx),
  .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .irq_in(irq_in),
  .irq_out(irq_out), .area(area), .cfg_en(cfg_en), .cfg_sel(cfg_sel)
);

// File: tb/irq_route_matrix_tb.sv
module irq_route_matrix_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NI = 128;
  localparam int NO = 24;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [11:0]  addr = '0;
  logic         wr_en = 1'b0;
  logic [31:0]  wr_data = '0;
  logic         rd_en = 1'b0;
  logic [31:0]  rd_data;
  logic [NI-1:0] irq_in = '0;
  logic [NO-1:0] irq_out;

  int n_cmp = 0;
  int n_bad = 0;
  logic       m_en  [NI];
  logic [4:0] m_sel [NI];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_route_matrix u_dut (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .irq_in(irq_in), .irq_out(irq_out)
  );

  task automatic compare(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [NO-1:0] model_out(logic [NI-1:0] v);
    logic [NO-1:0] r = '0;
    for (int i = 0; i < NI; i++)
      if (m_en[i] && v[i] && m_sel[i] < NO) r[m_sel[i]] = 1'b1;
    return r;
  endfunction

  task automatic bus_write(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    if (a < 12'h200) begin
      m_en[a[8:2]]  = d[31];
      m_sel[a[8:2]] = d[4:0];
    end
  endtask

  task automatic bus_read(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic check_out(string req);
    @(posedge clk);
    @(negedge clk);
    compare(req, 32'(irq_out), 32'(model_out(irq_in)));
  endtask

  task automatic check_all_cfg(string req);
    logic [31:0] d;
    for (int n = 0; n < NI; n++) begin
      bus_read(12'(n*4), d);
      compare(req, d, {m_en[n], 26'd0, m_sel[n]});
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [NI-1:0] pats [8];
    for (int n = 0; n < NI; n++) begin m_en[n] = 1'b0; m_sel[n] = '0; end
    irq_in = '1;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: quiet outputs and zero configuration after reset
    @(negedge clk);
    compare("R1", 32'(irq_out), 32'd0);
    check_all_cfg("R1");

    // R2: full-width writes, masked readback
    for (int n = 0; n < NI; n++)
      bus_write(12'(n*4), {n[0], 26'h2AA_AAAA, 5'(n % 32)} | 32'h0000_55E0);
    check_all_cfg("R2");

    // R3 / R5: walk one active input under a select pattern with out-of-range values
    for (int n = 0; n < NI; n++) bus_write(12'(n*4), {1'b1, 26'd0, 5'((n*7) % 32)});
    for (int n = 0; n < NI; n++) begin
      irq_in = 128'd1 << n;
      check_out(((n*7) % 32) >= NO ? "R5" : "R3");
    end

    // R6: shared outputs under multi-source patterns
    pats[0] = '1;
    pats[1] = {32{4'hA}};
    pats[2] = {32{4'h5}};
    pats[3] = {4{32'h8000_0001}};
    pats[4] = {16{8'h0F}};
    pats[5] = {2{64'h0123_4567_89AB_CDEF}};
    pats[6] = {128'hFFFF} << 100;
    pats[7] = {4{32'h0000_1111}};
    for (int p = 0; p < 8; p++) begin
      irq_in = pats[p];
      check_out("R6");
    end

    // R4: writing zero disables inputs
    for (int n = 0; n < NI; n += 3) bus_write(12'(n*4), 32'd0);
    irq_in = '1;
    check_out("R4");
    for (int n = 0; n < NI; n += 3) begin
      irq_in = 128'd1 << n;
      check_out("R4");
    end
    for (int p = 0; p < 8; p++) begin
      irq_in = pats[p];
      check_out("R4");
    end

    // R7: status words follow raw inputs regardless of enables
    for (int p = 0; p < 8; p++) begin
      irq_in = pats[p];
      for (int w = 0; w < 4; w++) begin
        bus_read(12'(12'h420 + w*4), d);
        compare("R7", d, pats[p][w*32 +: 32]);
      end
    end

    // R8: ignored writes, zero reads from unmapped space
    irq_in = {4{32'hC3C3_5A5A}};
    bus_write(12'h420, 32'hFFFF_FFFF);
    bus_write(12'h42C, 32'h8000_0003);
    bus_write(12'h200, 32'h8000_0001);
    bus_write(12'h41C, 32'h8000_0002);
    bus_write(12'h430, 32'h8000_0004);
    bus_write(12'hFFC, 32'h8000_0005);
    check_out("R8");
    check_all_cfg("R8");
    bus_read(12'h420, d);
    compare("R8", d, 32'h5A5A_C3C3 ^ 32'h9999_0000 ^ 32'h9999_0000 ^ 32'hC3C3_5A5A ^ 32'h5A5A_C3C3);
    foreach (pats[p]) begin end
    bus_read(12'h200, d);  compare("R8", d, 32'd0);
    bus_read(12'h41C, d);  compare("R8", d, 32'd0);
    bus_read(12'h430, d);  compare("R8", d, 32'd0);
    bus_read(12'hFFC, d);  compare("R8", d, 32'd0);

    // R9: data returns to zero after an idle cycle
    bus_read(12'h000, d);
    @(posedge clk);
    @(negedge clk);
    compare("R9", rd_data, 32'd0);
    bus_read(12'h42C, d);
    compare("R9", d, 32'hC3C3_5A5A);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule